// File: doc/BRIEF.md
# Fault-Aware Slice Gathering Network

This block rebuilds a full-width data word from an upstream data path that is cut into four equal slices, any of which may be permanently broken. A per-slice health vector tells the block which slices still carry data. The block then collects the word through the surviving slices over one, two or four cycles, using time-division multiplexing, and places the fragments in a storage register.

Three transfer widths exist. With every slice healthy the word arrives in one cycle. With two or three healthy slices the block uses exactly two of them and takes two cycles; three healthy slices are treated as two. With one healthy slice it takes four cycles. A ready flag marks the moment the whole word is present. Logic that reads the storage register waits for that flag. The upstream side is held back while a finished word has not yet been consumed. With no healthy slice the block flags a dead path and never completes a word.

The block sits between a sliced link or buffer and the logic that needs whole words. Fault detection and routing are handled elsewhere.

Top module: `slice_gather`

## Requirements
- R1: After reset, out_ready and in_stall are 0 and dead_err is 0 while at least one health bit is 1.
- R2: Slice i occupies in_slices bits [16*i+15 : 16*i] and is described by health bit i, where 1 means healthy. Slice index 3 is the most significant slice.
- R3: With health 4'b1111, one accepted cycle writes the whole in_slices value into out_word, and out_ready is 1 in the following cycle.
- R4: With exactly three healthy slices, a word takes two accepted cycles, the same as with two healthy slices.
- R5: In two-slice mode the block uses the two healthy slices with the lowest indices. The higher-indexed slice of that pair carries the upper 16 bits of each 32-bit fragment, and the other slices are ignored.
- R6: In two-slice mode, the first fragment lands in out_word[63:32] and the second in out_word[31:0].
- R7: In one-slice mode, four fragments arrive on the single healthy slice and fill out_word[63:48], [47:32], [31:16] and [15:0], in that order.
- R8: out_ready rises in the cycle after the last fragment of a word is accepted, and is 0 while a word is only partly collected.
- R9: While out_ready is 1 and out_take is 0, in_stall is 1, and in_valid has no effect on out_word or out_ready.
- R10: The health vector is sampled only at the first fragment of a word. Changing it in the middle of a word does not alter the mode or the slice choice for that word.
- R11: With health 4'b0000 at the start of a word, dead_err and in_stall are 1, input is ignored, and out_ready stays 0.
- R12: When out_take and an accepted in_valid fall in the same cycle, the finished word is consumed and the new fragment is taken in that cycle, without a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_slices | input | NSLICE*SLICE_W | Upstream slice data, slice i at bits [SLICE_W*i +: SLICE_W] |
| in_valid | input | 1 | Upstream fragment is present |
| in_stall | output | 1 | Back-pressure to upstream; a fragment is accepted when in_valid is 1 and in_stall is 0 |
| health | input | NSLICE | Per-slice health, 1 means usable |
| out_word | output | NSLICE*SLICE_W | Storage register contents |
| out_ready | output | 1 | The full word in out_word is valid |
| out_take | input | 1 | Downstream consumes the ready word |
| dead_err | output | 1 | No usable slice is available for the next word |

## Verification
The bench builds the block with its default parameters: four 16-bit slices. At that size every health pattern can be reached directly, including the three-healthy case, pairs that skip a broken slice in the middle, a lone surviving top or bottom slice, and the all-broken case. The expected words are collected into a scoreboard as each word is sent, through an independent model of fragment order and pair choice. Directed sequences with consumption paused probe the ready timing, the hold-off while a word is waiting, a health change in the middle of a word, and a take that coincides with a new fragment.

// File: rtl/slice_gather_pkg.sv
package slice_gather_pkg;

    typedef enum logic [1:0] {
        XM_DEAD = 2'd0,
        XM_ONE  = 2'd1,
        XM_PAIR = 2'd2,
        XM_FULL = 2'd3
    } xfer_mode_e;

    typedef struct packed {
        xfer_mode_e mode;
        logic [7:0] lo_idx;
        logic [7:0] hi_idx;
    } route_sel_t;

    function automatic int unsigned frags_needed(xfer_mode_e m, int unsigned nslice);
        case (m)
            XM_ONE:  return nslice;
            XM_PAIR: return nslice / 2;
            default: return 1;
        endcase
    endfunction

endpackage

// File: rtl/slice_gather_decode.sv
module slice_gather_decode
    import slice_gather_pkg::*;
#(
    parameter int NSLICE = 4
) (
    input  logic [NSLICE-1:0] health,
    output route_sel_t        sel
);
    localparam int CW = $clog2(NSLICE + 1);
    localparam int IW = $clog2(NSLICE);

    logic [CW-1:0] n_ok;
    logic          lo_found;
    logic          hi_found;
    logic [7:0]    lo_i;
    logic [7:0]    hi_i;

    always_comb begin
        n_ok     = '0;
        lo_found = 1'b0;
        hi_found = 1'b0;
        lo_i     = '0;
        hi_i     = '0;
        for (int i = 0; i < NSLICE; i++) begin
            if (health[i]) begin
                n_ok = n_ok + 1'b1;
                if (!lo_found) begin
                    lo_found = 1'b1;
                    lo_i     = 8'(i);
                end else if (!hi_found) begin
                    hi_found = 1'b1;
                    hi_i     = 8'(i);
                end
            end
        end
        sel.lo_idx = lo_i;
        sel.hi_idx = hi_i;
        if (n_ok == CW'(NSLICE))
            sel.mode = XM_FULL;
        else if (n_ok >= CW'(2))
            sel.mode = XM_PAIR;
        else if (n_ok == CW'(1))
            sel.mode = XM_ONE;
        else
            sel.mode = XM_DEAD;
    end

    always_comb begin
        if (sel.mode == XM_PAIR) begin
            // R5
            pair_order_chk: assert (health[sel.lo_idx[IW-1:0]] && health[sel.hi_idx[IW-1:0]]
                                    && (sel.lo_idx < sel.hi_idx));
        end
    end

endmodule

// File: rtl/slice_gather_mux.sv
module slice_gather_mux
    import slice_gather_pkg::*;
#(
    parameter int SLICE_W = 16,
    parameter int NSLICE  = 4
) (
    input  route_sel_t                  sel,
    input  logic [NSLICE*SLICE_W-1:0]   slices,
    output logic [2*SLICE_W-1:0]        pair_frag,
    output logic [SLICE_W-1:0]          one_frag
);
    localparam int IW = $clog2(NSLICE);

    logic [IW-1:0] lo;
    logic [IW-1:0] hi;

    assign lo        = sel.lo_idx[IW-1:0];
    assign hi        = sel.hi_idx[IW-1:0];
    assign one_frag  = slices[int'(lo)*SLICE_W +: SLICE_W];
    assign pair_frag = {slices[int'(hi)*SLICE_W +: SLICE_W], slices[int'(lo)*SLICE_W +: SLICE_W]};

endmodule

// File: rtl/slice_gather_store.sv
module slice_gather_store
    import slice_gather_pkg::*;
#(
    parameter int SLICE_W = 16,
    parameter int NSLICE  = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        accept,
    input  logic                        take,
    input  xfer_mode_e                  mode,
    input  logic [NSLICE*SLICE_W-1:0]   full_frag,
    input  logic [2*SLICE_W-1:0]        pair_frag,
    input  logic [SLICE_W-1:0]          one_frag,
    output logic [NSLICE*SLICE_W-1:0]   word_q,
    output logic                        ready_q,
    output logic                        cnt_zero
);
    localparam int CNTW  = $clog2(NSLICE);
    localparam int PAIRW = 2 * SLICE_W;
    localparam int HALFN = NSLICE / 2;

    logic [CNTW-1:0] cnt_q;
    logic            last_frag;
    int              pair_pos;
    int              one_pos;

    assign cnt_zero  = (cnt_q == '0);
    assign last_frag = (int'(cnt_q) == int'(frags_needed(mode, NSLICE)) - 1);

    always_comb begin
        pair_pos = (HALFN - 1 - int'(cnt_q)) * PAIRW;
        one_pos  = (NSLICE - 1 - int'(cnt_q)) * SLICE_W;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q  <= '0;
            cnt_q   <= '0;
            ready_q <= 1'b0;
        end else begin
            if (take)
                ready_q <= 1'b0;
            if (accept) begin
                case (mode)
                    XM_FULL: word_q                   <= full_frag;
                    XM_PAIR: word_q[pair_pos +: PAIRW] <= pair_frag;
                    XM_ONE:  word_q[one_pos +: SLICE_W] <= one_frag;
                    default: ;
                endcase
                if (last_frag) begin
                    cnt_q   <= '0;
                    ready_q <= 1'b1;
                end else begin
                    cnt_q   <= cnt_q + 1'b1;
                end
            end
        end
    end

    // R8
    ready_after_fill_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ready_q) |-> $past(accept));

    // R8
    partial_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
        !cnt_zero |-> !ready_q);

    // R9
    hold_word_chk: assert property (@(posedge clk) disable iff (rst)
        (ready_q && !take) |=> (ready_q && $stable(word_q)));

endmodule

// File: rtl/slice_gather.sv
module slice_gather
    import slice_gather_pkg::*;
#(
    parameter int SLICE_W = 16,
    parameter int NSLICE  = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NSLICE*SLICE_W-1:0]   in_slices,
    input  logic                        in_valid,
    output logic                        in_stall,
    input  logic [NSLICE-1:0]           health,
    output logic [NSLICE*SLICE_W-1:0]   out_word,
    output logic                        out_ready,
    input  logic                        out_take,
    output logic                        dead_err
);
    route_sel_t          sel;
    logic [NSLICE-1:0]   held_health_q;
    logic [NSLICE-1:0]   eff_health;
    logic [2*SLICE_W-1:0] pair_frag;
    logic [SLICE_W-1:0]  one_frag;
    logic                accept;
    logic                cnt_zero;
    logic                take;

    // The health vector counts only at the start of a word.
    assign eff_health = cnt_zero ? health : held_health_q;
    assign dead_err   = (sel.mode == XM_DEAD);
    assign take       = out_take && out_ready;
    assign in_stall   = dead_err || (out_ready && !out_take);
    assign accept     = in_valid && !in_stall;

    always_ff @(posedge clk) begin
        if (rst)
            held_health_q <= '0;
        else if (accept && cnt_zero)
            held_health_q <= health;
    end

    slice_gather_decode #(.NSLICE(NSLICE)) u_decode (
        .health (eff_health),
        .sel    (sel)
    );

    slice_gather_mux #(.SLICE_W(SLICE_W), .NSLICE(NSLICE)) u_mux (
        .sel       (sel),
        .slices    (in_slices),
        .pair_frag (pair_frag),
        .one_frag  (one_frag)
    );

    slice_gather_store #(.SLICE_W(SLICE_W), .NSLICE(NSLICE)) u_store (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .take      (take),
        .mode      (sel.mode),
        .full_frag (in_slices),
        .pair_frag (pair_frag),
        .one_frag  (one_frag),
        .word_q    (out_word),
        .ready_q   (out_ready),
        .cnt_zero  (cnt_zero)
    );

    // R11
    dead_no_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (dead_err && !out_ready) |=> !out_ready);

endmodule

// File: tb/slice_gather_bench.sv
module slice_gather_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] in_slices = '0;
    logic        in_valid = 1'b0;
    logic        in_stall;
    logic [3:0]  health = 4'b1111;
    logic [63:0] out_word;
    logic        out_ready;
    logic        out_take;
    logic        dead_err;
    logic        take_en = 1'b0;

    int          n_checks = 0;
    int          n_fails  = 0;
    int          cyc      = 0;
    bit          done     = 1'b0;
    logic [63:0] exp_q[$];

    always #5 clk = ~clk;

    assign out_take = out_ready && take_en;

    slice_gather u_slice_gather (
        .clk(clk), .rst(rst), .in_slices(in_slices), .in_valid(in_valid),
        .in_stall(in_stall), .health(health), .out_word(out_word),
        .out_ready(out_ready), .out_take(out_take), .dead_err(dead_err)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Bench model of mode and pair choice (R4, R5).
    function automatic int n_frags(input logic [3:0] h);
        int n = 0;
        for (int i = 0; i < 4; i++) n += int'(h[i]);
        if (n == 4) return 1;
        if (n >= 2) return 2;
        return 4;
    endfunction

    function automatic logic [63:0] frag(input logic [63:0] w, input logic [3:0] h, input int k);
        logic [63:0] v;
        int lo = -1;
        int hi = -1;
        for (int i = 0; i < 4; i++) v[i*16 +: 16] = 16'hBAD0 + 16'(i) + 16'(k << 4);
        for (int i = 0; i < 4; i++)
            if (h[i]) begin
                if (lo < 0) lo = i;
                else if (hi < 0) hi = i;
            end
        case (n_frags(h))
            1: v = w;
            2: begin
                v[hi*16 +: 16] = w[(1-k)*32 + 16 +: 16];
                v[lo*16 +: 16] = w[(1-k)*32 +: 16];
            end
            default: v[lo*16 +: 16] = w[(3-k)*16 +: 16];
        endcase
        return v;
    endfunction

    task automatic put(input logic [3:0] h, input logic [63:0] sl);
        @(negedge clk);
        health    = h;
        in_slices = sl;
        in_valid  = 1'b1;
        #1;
        while (in_stall) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic send_word(input logic [63:0] w, input logic [3:0] h);
        exp_q.push_back(w);
        for (int k = 0; k < n_frags(h); k++) put(h, frag(w, h, k));
    endtask

    // Monitor: compares every word as it is consumed.
    always @(negedge clk) begin
        #2;
        if (!rst && out_ready && out_take) begin
            if (exp_q.size() == 0) begin
                check("R3-R7 scoreboard unexpected word", out_word, 64'hx);
            end else begin
                logic [63:0] e;
                e = exp_q.pop_front();
                check("R5/R6/R7 scoreboard word", out_word, e);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            n_fails++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] w1;
        logic [63:0] w2;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check("R1 reset ready", {63'd0, out_ready}, 64'd0);
        check("R1 reset stall", {63'd0, in_stall}, 64'd0);
        check("R1 reset dead", {63'd0, dead_err}, 64'd0);

        // R3 full word in one cycle, R9 hold-off, R12 take with new fragment
        w1 = 64'h0123_4567_89AB_CDEF;
        w2 = 64'hFEDC_BA98_7654_3210;
        exp_q.push_back(w1);
        put(4'b1111, w1);
        @(negedge clk);
        check("R3 ready after one fragment", {63'd0, out_ready}, 64'd1);
        check("R3 word captured", out_word, w1);
        check("R9 stall while waiting", {63'd0, in_stall}, 64'd1);
        in_valid  = 1'b1;
        in_slices = 64'h5555_AAAA_5555_AAAA;
        repeat (2) @(negedge clk);
        check("R9 word held under stall", out_word, w1);
        check("R9 ready held under stall", {63'd0, out_ready}, 64'd1);
        exp_q.push_back(w2);
        in_slices = w2;
        take_en   = 1'b1;
        @(negedge clk);
        check("R12 next word taken with consume", out_word, w2);
        check("R12 ready stays up", {63'd0, out_ready}, 64'd1);
        in_valid = 1'b0;
        @(negedge clk);
        take_en = 1'b0;

        // R4 three healthy slices behave as two
        w1 = 64'h1111_2222_3333_4444;
        exp_q.push_back(w1);
        put(4'b0111, frag(w1, 4'b0111, 0));
        @(negedge clk);
        check("R8 not ready after first pair", {63'd0, out_ready}, 64'd0);
        put(4'b0111, frag(w1, 4'b0111, 1));
        @(negedge clk);
        check("R4 ready after two fragments", {63'd0, out_ready}, 64'd1);
        check("R6 pair word assembled", out_word, w1);
        take_en = 1'b1;
        @(negedge clk);
        take_en = 1'b0;

        // R7 single slice: ready only after fourth fragment
        w1 = 64'hA1B2_C3D4_E5F6_0789;
        exp_q.push_back(w1);
        for (int k = 0; k < 3; k++) put(4'b0100, frag(w1, 4'b0100, k));
        @(negedge clk);
        check("R8 not ready after three singles", {63'd0, out_ready}, 64'd0);
        check("R7 top fragments placed", {out_word[63:16], 16'd0}, {w1[63:16], 16'd0});
        put(4'b0100, frag(w1, 4'b0100, 3));
        @(negedge clk);
        check("R7 ready after four singles", {63'd0, out_ready}, 64'd1);
        take_en = 1'b1;
        @(negedge clk);

        // R10 health change mid-word is ignored
        w1 = 64'h0F0F_1E1E_2D2D_3C3C;
        exp_q.push_back(w1);
        put(4'b0001, frag(w1, 4'b0001, 0));
        for (int k = 1; k < 4; k++) put(4'b1111, frag(w1, 4'b0001, k));

        // R5/R2 streamed through the scoreboard over several patterns
        send_word(64'hDEAD_BEEF_CAFE_F00D, 4'b1010);
        send_word(64'h1357_9BDF_2468_ACE0, 4'b0101);
        send_word(64'h8000_0000_0000_0001, 4'b1000);
        send_word(64'h0000_FFFF_0000_FFFF, 4'b0001);
        send_word(64'h7766_5544_3322_1100, 4'b1111);
        send_word(64'h0A0B_0C0D_0E0F_1011, 4'b1101);
        send_word(64'hFFFF_0000_FFFF_0000, 4'b0011);
        repeat (4) @(negedge clk);
        check("R5 scoreboard drained", 64'(exp_q.size()), 64'd0);
        take_en = 1'b0;

        // R11 dead path
        @(negedge clk);
        health    = 4'b0000;
        in_valid  = 1'b1;
        in_slices = 64'h1234_1234_1234_1234;
        #1;
        check("R11 dead flag", {63'd0, dead_err}, 64'd1);
        check("R11 dead stall", {63'd0, in_stall}, 64'd1);
        repeat (3) @(negedge clk);
        check("R11 never ready", {63'd0, out_ready}, 64'd0);
        in_valid = 1'b0;
        health   = 4'b1111;
        #1;
        check("R11 dead clears with healthy slice", {63'd0, dead_err}, 64'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule